// File: doc/BRIEF.md
# Decimal-Digit Table Constant Multiplier

This block multiplies a two-digit decimal operand by a constant that is fixed when the design is elaborated. The operand arrives as two BCD digits, tens and units, qualified by a valid strobe. The result leaves as a plain binary product with its own valid flag. No general-purpose multiplier is used anywhere in the datapath.

A small table is built at elaboration from the constant. It holds the constant times zero through five, and each entry is formed by repeated addition. A digit of five or less reads one table entry. A digit from six to nine reads the entry for five and the entry for the rest, and adds the two. The tens partial product is then scaled by ten as the sum of its copies shifted left by three and by one. The units partial product is added to that sum to give the result.

The datapath has two register stages. The first holds the two digit partial products and the digit check. The second holds the scaled sum. A digit code of ten or more marks the operand as illegal. In that case the product is forced to zero and an error flag is raised.

Top module: `bcd_const_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, product and digit_err are all zero.
- R2: For tens = 0 and units u in 0..5, the product is u·K, read straight from the multiples table.
- R3: A units or tens digit in 6..9 produces the same result as true multiplication, with its partial product formed from the table entries for five and for (digit − 5).
- R4: For every tens digit T and units digit U in 0..9, product = (10·T + U)·K.
- R5: The product is PW = KW + 7 bits wide, and 99·K appears there without truncation for every K of KW bits.
- R6: An input accepted with in_valid high at a rising edge produces out_valid high exactly two rising edges later. The block accepts a new operand every cycle, and out_valid is low for cycles that carried no input.
- R7: A digit code of 10 to 15 (binary 1010 to 1111) on either digit gives digit_err = 1 and product = 0, with out_valid high at the normal latency.
- R8: While no result is delivered (out_valid low), product and digit_err keep the values of the last delivered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand digits are valid this cycle |
| tens_digit | input | 4 | BCD tens digit |
| units_digit | input | 4 | BCD units digit |
| out_valid | output | 1 | Product and error flag are valid |
| product | output | KW+7 | Binary product (10·T+U)·K |
| digit_err | output | 1 | An operand digit was not a legal BCD code |

## Verification
The bench sweeps all 256 digit pairs back to back on two constants, one of them the largest that fits in KW bits. This catches a wrong composition for digits six to nine, a wrong times-ten shift pair, and truncation of 99·K. Illegal codes on either digit, alone or together, check that the error path zeroes the product rather than passing on a stale value or a table sum read at a wrapped index. Idle gaps between operands check that a design which misses the valid qualification, or drops the held result, shows a spurious out_valid or a changed product.

// File: rtl/bcd_kcm_pkg.sv
package bcd_kcm_pkg;

    // Number of table locations: multiples 0..5 of the constant.
    localparam int unsigned MULT_SLOTS = 6;
    localparam int unsigned DIGIT_W    = 4;
    localparam int unsigned FIVE       = 5;
    localparam int unsigned NINE       = 9;

    typedef enum logic [1:0] {
        DIG_DIRECT   = 2'd0,   // 0..5, one table read
        DIG_COMPOSED = 2'd1,   // 6..9, entry five plus remainder entry
        DIG_ILLEGAL  = 2'd2    // 10..15
    } digit_class_e;

    // Width of one table entry: 5*K < 8*2^KW
    function automatic int unsigned table_width(input int unsigned kw);
        return kw + 3;
    endfunction

    // Width of one digit partial product: 9*K < 16*2^KW
    function automatic int unsigned pp_width(input int unsigned kw);
        return kw + 4;
    endfunction

    // Width of the final product: 99*K < 128*2^KW
    function automatic int unsigned prod_width(input int unsigned kw);
        return kw + 7;
    endfunction

    function automatic digit_class_e classify(input logic [DIGIT_W-1:0] d);
        if (d <= DIGIT_W'(FIVE))      return DIG_DIRECT;
        else if (d <= DIGIT_W'(NINE)) return DIG_COMPOSED;
        else                          return DIG_ILLEGAL;
    endfunction

endpackage

// File: rtl/multiple_table.sv
module multiple_table
    import bcd_kcm_pkg::*;
#(
    parameter int unsigned KW = 8,
    parameter logic [KW-1:0] K = KW'(47),
    localparam int unsigned TW = table_width(KW)
) (
    output logic [MULT_SLOTS-1:0][TW-1:0] entries
);

    assign entries[0] = '0;

    // Each slot is the previous slot plus the constant: no multiply.
    for (genvar i = 1; i < MULT_SLOTS; i++) begin : g_slot
        assign entries[i] = entries[i-1] + TW'(K);
    end

endmodule

// File: rtl/digit_partial.sv
module digit_partial
    import bcd_kcm_pkg::*;
#(
    parameter int unsigned KW = 8,
    localparam int unsigned TW  = table_width(KW),
    localparam int unsigned PPW = pp_width(KW)
) (
    input  logic [DIGIT_W-1:0]            digit,
    input  logic [MULT_SLOTS-1:0][TW-1:0] entries,
    output logic [PPW-1:0]                partial,
    output logic                          illegal
);

    digit_class_e cls;
    logic [2:0]   direct_idx;
    logic [2:0]   rest_idx;

    always_comb begin
        cls        = classify(digit);
        direct_idx = digit[2:0];
        rest_idx   = 3'(digit - DIGIT_W'(FIVE));
        partial    = '0;
        illegal    = 1'b0;
        unique case (cls)
            DIG_DIRECT:   partial = PPW'(entries[direct_idx]);
            DIG_COMPOSED: partial = PPW'(entries[FIVE]) + PPW'(entries[rest_idx]);
            default: begin
                partial = '0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/times_ten.sv
module times_ten #(
    parameter int unsigned IW = 12,
    parameter int unsigned OW = 15
) (
    input  logic [IW-1:0] x,
    output logic [OW-1:0] y
);

    // 10x = 8x + 2x
    assign y = (OW'(x) << 3) + (OW'(x) << 1);

endmodule

// File: rtl/bcd_const_mult.sv
module bcd_const_mult
    import bcd_kcm_pkg::*;
#(
    parameter int unsigned KW = 8,
    parameter logic [KW-1:0] K = KW'(47),
    localparam int unsigned TW  = table_width(KW),
    localparam int unsigned PPW = pp_width(KW),
    localparam int unsigned PW  = prod_width(KW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DIGIT_W-1:0] tens_digit,
    input  logic [DIGIT_W-1:0] units_digit,
    output logic               out_valid,
    output logic [PW-1:0]      product,
    output logic               digit_err
);

    localparam logic [PW-1:0] MAX_PRODUCT = PW'(99) * PW'(K);

    logic [MULT_SLOTS-1:0][TW-1:0] entries;
    logic [PPW-1:0] tens_pp, units_pp;
    logic           tens_bad, units_bad;

    multiple_table #(.KW(KW), .K(K)) u_table (.entries(entries));

    digit_partial #(.KW(KW)) u_tens (
        .digit(tens_digit), .entries(entries),
        .partial(tens_pp), .illegal(tens_bad)
    );

    digit_partial #(.KW(KW)) u_units (
        .digit(units_digit), .entries(entries),
        .partial(units_pp), .illegal(units_bad)
    );

    // Stage 1: digit partial products
    logic           s1_valid;
    logic [PPW-1:0] s1_tens_pp, s1_units_pp;
    logic           s1_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid    <= 1'b0;
            s1_tens_pp  <= '0;
            s1_units_pp <= '0;
            s1_err      <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_tens_pp  <= tens_pp;
                s1_units_pp <= units_pp;
                s1_err      <= tens_bad | units_bad;
            end
        end
    end

    // Stage 2: scale tens by ten and add units
    logic [PW-1:0] tens_scaled;
    logic [PW-1:0] sum;

    times_ten #(.IW(PPW), .OW(PW)) u_scale (.x(s1_tens_pp), .y(tens_scaled));

    assign sum = tens_scaled + PW'(s1_units_pp);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            product   <= '0;
            digit_err <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                product   <= s1_err ? '0 : sum;
                digit_err <= s1_err;
            end
        end
    end

    // Assertions
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
    p_deliver_r6: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);
    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && digit_err) |-> (product == '0));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !digit_err) |-> (product <= MAX_PRODUCT));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> ($stable(product) && $stable(digit_err)));

endmodule

// File: tb/bcd_const_mult_bench.sv
module bcd_const_mult_bench;

    localparam int CLK_PERIOD = 10;
    localparam int KW = 8;
    localparam int PW = KW + 7;
    localparam logic [KW-1:0] KA = 8'd47;
    localparam logic [KW-1:0] KB = 8'd255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [3:0] tens_digit = '0, units_digit = '0;
    logic out_valid_a, out_valid_b, err_a, err_b;
    logic [PW-1:0] prod_a, prod_b;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_const_mult #(.KW(KW), .K(KA)) u_bcd_const_mult (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .tens_digit(tens_digit), .units_digit(units_digit),
        .out_valid(out_valid_a), .product(prod_a), .digit_err(err_a));

    bcd_const_mult #(.KW(KW), .K(KB)) u_bcd_const_mult_max (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .tens_digit(tens_digit), .units_digit(units_digit),
        .out_valid(out_valid_b), .product(prod_b), .digit_err(err_b));

    function automatic int expect_prod(int t, int u, int k);
        if (t > 9 || u > 9) return 0;
        return (10 * t + u) * k;
    endfunction

    function automatic string tag_of(int t, int u);
        if (t > 9 || u > 9)   return "R7";
        if (t == 9 && u == 9) return "R5";
        if (t == 0 && u <= 5) return "R2";
        if (t > 5 || u > 5)   return "R3";
        return "R4";
    endfunction

    task automatic check(string tag, int vact, int pact, int eact,
                         int vexp, int pexp, int eexp);
        tests++;
        if (vact != vexp || pact != pexp || eact != eexp) begin
            fails++;
            $display("FAIL %s: valid/product/err = %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, vact, pact, eact, vexp, pexp, eexp);
        end
    endtask

    task automatic check_pair(string tag, int vexp, int t, int u,
                              int pa_hold, int pb_hold, int e_hold);
        int pa, pb, e;
        if (vexp != 0) begin
            pa = expect_prod(t, u, int'(KA));
            pb = expect_prod(t, u, int'(KB));
            e  = (t > 9 || u > 9) ? 1 : 0;
        end else begin
            pa = pa_hold; pb = pb_hold; e = e_hold;
        end
        check(tag, int'(out_valid_a), int'(prod_a), int'(err_a), vexp, pa, e);
        check(tag, int'(out_valid_b), int'(prod_b), int'(err_b), vexp, pb, e);
    endtask

    initial begin
        int tv [256];
        int uv [256];
        repeat (3) @(negedge clk);
        // R1: during reset
        check_pair("R1", 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check_pair("R1", 0, 0, 0, 0, 0, 0);

        // R2 R3 R4 R5 R6 R7: full sweep, one operand per cycle
        for (int i = 0; i < 256; i++) begin
            tv[i] = i / 16;
            uv[i] = i % 16;
        end
        for (int s = 0; s < 258; s++) begin
            if (s >= 2)
                check_pair(tag_of(tv[s-2], uv[s-2]), 1, tv[s-2], uv[s-2], 0, 0, 0);
            if (s < 256) begin
                in_valid = 1'b1;
                tens_digit = 4'(tv[s]);
                units_digit = 4'(uv[s]);
            end else begin
                in_valid = 1'b0;
                tens_digit = 4'd3;
                units_digit = 4'd3;
            end
            @(negedge clk);
        end
        // last operand was 15/15: illegal; R8 hold after idle, digits toggling
        for (int s = 0; s < 4; s++) begin
            tens_digit = 4'(s + 1);
            units_digit = 4'(s + 2);
            check_pair("R8", 0, 0, 0, 0, 0, 1);
            @(negedge clk);
        end

        // R6 R8: isolated operand, then idle
        in_valid = 1'b1; tens_digit = 4'd9; units_digit = 4'd9;
        @(negedge clk);
        in_valid = 1'b0; tens_digit = 4'd0; units_digit = 4'd0;
        check_pair("R6", 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        check_pair("R5", 1, 9, 9, 0, 0, 0);
        @(negedge clk);
        check_pair("R8", 0, 0, 0, 99 * 47, 99 * 255, 0);
        @(negedge clk);
        check_pair("R8", 0, 0, 0, 99 * 47, 99 * 255, 0);

        // R7: tens legal, units illegal, isolated
        in_valid = 1'b1; tens_digit = 4'd4; units_digit = 4'd10;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_pair("R7", 1, 4, 10, 0, 0, 0);
        @(negedge clk);
        check_pair("R8", 0, 0, 0, 0, 0, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule